// File: doc/BRIEF.md
# 100BASE-TX Transmit Code-Group Encoder

This block turns the nibble stream a MAC presents on its media-independent transmit side into the 5-bit code-group stream of a 100BASE-TX physical coding sublayer. It runs on the 125 MHz bit clock and divides that clock by five internally. The resulting one-cycle strobe tells the MAC side when a nibble, with its enable and error flags, is taken in. Each strobe yields exactly one code-group.

Data nibbles are translated through the fixed 4B/5B table. The encoder also handles the framing. It replaces the first two preamble nibbles of a frame with the start-of-stream pair J/K. After the enable drops it appends the end-of-stream pair T/R. Between frames it fills the line with IDLE. An errored data nibble is turned into a HALT code-group, but the delimiters are never changed.

A shift register serialises the code-group stream, most significant bit first, at five bits per nibble period. It feeds the downstream scrambler, which lies outside this block.

Top module: `fx_cg_encoder`

## Requirements
- R1: In the data phase of a frame with the error flag low, nibble values 0x0..0xF become code-groups 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101 (written code_grp[4] down to code_grp[0]).
- R2: Outside a frame the output is IDLE 11111 at every nibble strobe. The error flag has no effect while the enable is low.
- R3: At the first strobe with the enable high after idle, the output is J 11000. At the next strobe it is K 10001. The two nibbles taken in at those strobes are discarded whatever their value.
- R4: At the first strobe in the data phase with the enable low, the output is T 01101. At the next strobe it is R 00111, and after that IDLE follows.
- R5: In the data phase, a strobe with the enable and the error flag both high outputs HALT 00100 in place of the data code-group.
- R6: J, K, T and R are emitted unchanged when the error flag is high during their strobes.
- R7: If the enable drops at the J or K strobe, J and K are still completed, and T and R follow directly.
- R8: nib_tick is high for one cycle in every five. code_grp changes only at the clock edge that ends a cycle with nib_tick high.
- R9: In the k-th cycle (k = 0..4) after a strobe edge, ser_bit equals code_grp[4-k], so the most significant bit goes out first.
- R10: After reset, code_grp is IDLE 11111, ser_bit is 1, and the first nib_tick comes in the fifth cycle after reset is released.
- R11: The enable is ignored at the R strobe. A new frame whose enable is already high at that strobe begins with J at the strobe after R.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz bit clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Transmit enable from the MAC, sampled at the nib_tick edge |
| tx_er | input | 1 | Transmit error from the MAC, sampled at the nib_tick edge |
| txd | input | 4 | Transmit nibble from the MAC, sampled at the nib_tick edge |
| nib_tick | output | 1 | One-cycle strobe every five bit clocks that marks nibble acceptance |
| code_grp | output | 5 | Current 5-bit code-group, bit 4 sent first |
| ser_bit | output | 1 | Serial code-group stream at the bit rate |

## Verification
The assertions assume that tx_en, tx_er and txd are held steady around the nib_tick edge, and that a frame lasts until the enable drops. They also assume that the only way out of R leads to IDLE or J. The bench drives its inputs only at the falling clock edge inside the cycle in which nib_tick is high, so every value it presents is taken in at exactly one strobe. Random frames are generated with a biased enable, so that both short frames and frames that end on J or K occur. Error pulses fall on delimiter and idle strobes as well as on data strobes.

// File: rtl/fx_cg_pkg.sv
package fx_cg_pkg;

    localparam int NIB_W = 4;
    localparam int CG_W  = 5;

    typedef logic [CG_W-1:0] cg_t;

    localparam cg_t CG_IDLE = 5'b11111;
    localparam cg_t CG_J    = 5'b11000;
    localparam cg_t CG_K    = 5'b10001;
    localparam cg_t CG_T    = 5'b01101;
    localparam cg_t CG_R    = 5'b00111;
    localparam cg_t CG_HALT = 5'b00100;

    typedef enum logic [1:0] {
        ENC_IDLE,
        ENC_SSD2,
        ENC_DATA,
        ENC_ESD2
    } enc_state_e;

    typedef struct packed {
        logic             en;
        logic             er;
        logic [NIB_W-1:0] dat;
    } tx_nib_t;

    function automatic cg_t nib_to_cg(input logic [NIB_W-1:0] n);
        cg_t c;
        case (n)
            4'h0: c = 5'b11110;
            4'h1: c = 5'b01001;
            4'h2: c = 5'b10100;
            4'h3: c = 5'b10101;
            4'h4: c = 5'b01010;
            4'h5: c = 5'b01011;
            4'h6: c = 5'b01110;
            4'h7: c = 5'b01111;
            4'h8: c = 5'b10010;
            4'h9: c = 5'b10011;
            4'hA: c = 5'b10110;
            4'hB: c = 5'b10111;
            4'hC: c = 5'b11010;
            4'hD: c = 5'b11011;
            4'hE: c = 5'b11100;
            default: c = 5'b11101;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fx_cg_tick.sv
module fx_cg_tick #(
    parameter int DIV = 5
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst)               phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                   phase <= phase + 1'b1;
    end

    assign tick = (phase == LAST);

    // R8
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        phase <= LAST);

    // R8
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/fx_cg_fsm.sv
module fx_cg_fsm
    import fx_cg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  tx_nib_t nib,
    output cg_t     code_q,
    output cg_t     code_nxt
);
    enc_state_e st_q, st_nxt;

    always_comb begin
        st_nxt   = st_q;
        code_nxt = CG_IDLE;
        unique case (st_q)
            ENC_IDLE: begin
                if (nib.en) begin
                    code_nxt = CG_J;
                    st_nxt   = ENC_SSD2;
                end
            end
            ENC_SSD2: begin
                code_nxt = CG_K;
                st_nxt   = ENC_DATA;
            end
            ENC_DATA: begin
                if (!nib.en) begin
                    code_nxt = CG_T;
                    st_nxt   = ENC_ESD2;
                end else if (nib.er) begin
                    code_nxt = CG_HALT;
                end else begin
                    code_nxt = nib_to_cg(nib.dat);
                end
            end
            default: begin
                code_nxt = CG_R;
                st_nxt   = ENC_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ENC_IDLE;
            code_q <= CG_IDLE;
        end else if (tick) begin
            st_q   <= st_nxt;
            code_q <= code_nxt;
        end
    end

    // R3
    j_then_k_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && code_q == CG_J) |=> code_q == CG_K);

    // R4
    t_then_r_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && code_q == CG_T) |=> code_q == CG_R);

    // R11
    r_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && code_q == CG_R) |=> (code_q == CG_IDLE || code_q == CG_J));

    // R2
    idle_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !nib.en && (code_q == CG_IDLE || code_q == CG_R)) |=> code_q == CG_IDLE);

    // R8
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(code_q));
endmodule

// File: rtl/fx_cg_shift.sv
module fx_cg_shift #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] par_in,
    output logic         ser
);
    logic [W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst)       sh <= '1;
        else if (load) sh <= par_in;
        else           sh <= {sh[W-2:0], 1'b0};
    end

    assign ser = sh[W-1];

    // R9
    load_msb_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> ser == $past(par_in[W-1]));

    // R9
    shift_step_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> ser == $past(sh[W-2]));
endmodule

// File: rtl/fx_cg_encoder.sv
module fx_cg_encoder
    import fx_cg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_en,
    input  logic       tx_er,
    input  logic [3:0] txd,
    output logic       nib_tick,
    output logic [4:0] code_grp,
    output logic       ser_bit
);
    tx_nib_t nib;
    cg_t     cg_q, cg_n;

    assign nib = '{en: tx_en, er: tx_er, dat: txd};

    fx_cg_tick #(.DIV(CG_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (nib_tick)
    );

    fx_cg_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tick     (nib_tick),
        .nib      (nib),
        .code_q   (cg_q),
        .code_nxt (cg_n)
    );

    fx_cg_shift #(.W(CG_W)) u_ser (
        .clk    (clk),
        .rst    (rst),
        .load   (nib_tick),
        .par_in (cg_n),
        .ser    (ser_bit)
    );

    assign code_grp = cg_q;

    // R9
    ser_lead_chk: assert property (@(posedge clk) disable iff (rst)
        nib_tick |=> ser_bit == code_grp[4]);

    // R6
    ssd_no_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (nib_tick && code_grp == CG_IDLE && tx_en) |=> code_grp == CG_J);
endmodule

// File: tb/tb_fx_cg_encoder.sv
module tb_fx_cg_encoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_en = 1'b0;
    logic       tx_er = 1'b0;
    logic [3:0] txd = 4'h0;
    logic       nib_tick;
    logic [4:0] code_grp;
    logic       ser_bit;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    typedef enum int {M_IDLE, M_K, M_DATA, M_R} mstate_e;
    mstate_e ms = M_IDLE;

    always #2 clk = ~clk;

    fx_cg_encoder dut (
        .clk(clk), .rst(rst), .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
        .nib_tick(nib_tick), .code_grp(code_grp), .ser_bit(ser_bit)
    );

    function automatic logic [4:0] ref_tbl(input logic [3:0] n);
        logic [4:0] t [16] = '{5'h1E, 5'h09, 5'h14, 5'h15, 5'h0A, 5'h0B, 5'h0E, 5'h0F,
                               5'h12, 5'h13, 5'h16, 5'h17, 5'h1A, 5'h1B, 5'h1C, 5'h1D};
        return t[n];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [4:0] act, input logic [4:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // precondition: at a negedge in a cycle with nib_tick high
    task automatic step(input bit en, input bit er, input logic [3:0] d, input string tag);
        logic [4:0] exp;
        logic [4:0] got;
        bit tick_ok;
        tx_en = en; tx_er = er; txd = d;
        case (ms)
            M_IDLE: if (en) begin exp = 5'b11000; ms = M_K; end else exp = 5'b11111;
            M_K:    begin exp = 5'b10001; ms = M_DATA; end
            M_DATA: if (!en) begin exp = 5'b01101; ms = M_R; end
                    else exp = er ? 5'b00100 : ref_tbl(d);
            default: begin exp = 5'b00111; ms = M_IDLE; end
        endcase
        tick_ok = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            got[4-k] = ser_bit;
            if (k == 0) chk(code_grp == exp, tag, code_grp, exp);
            if (k < 4 && nib_tick) tick_ok = 1'b0;
            if (k == 4 && (!nib_tick || code_grp != exp)) tick_ok = 1'b0;
        end
        // R9 serial order, R8 strobe spacing and hold
        chk(got == exp, "R9 serial", got, exp);
        chk(tick_ok, "R8 tick/hold", code_grp, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        int run;
        seed = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state and first strobe in fifth cycle
        chk(code_grp == 5'b11111 && ser_bit == 1'b1, "R10 reset", code_grp, 5'b11111);
        for (int k = 0; k < 4; k++) begin
            chk(!nib_tick, "R10 early tick", {4'b0, nib_tick}, 5'b0);
            @(negedge clk);
        end
        chk(nib_tick, "R10 first tick", {4'b0, nib_tick}, 5'b1);

        // R2 idle, error flag ignored when enable low
        step(0, 0, 4'h3, "R2 idle");
        step(0, 1, 4'hA, "R2 idle with er");
        // R3 J/K replaces preamble, R1 all 16 nibbles
        step(1, 0, 4'h5, "R3 J");
        step(1, 0, 4'h9, "R3 K");
        for (int n = 0; n < 16; n++) step(1, 0, 4'(n), "R1 data");
        // R5 HALT in data
        step(1, 1, 4'h7, "R5 halt");
        step(1, 0, 4'h7, "R1 after halt");
        // R4 T/R then idle, R6 er during T and R
        step(0, 1, 4'h0, "R6 T with er");
        step(0, 1, 4'h0, "R6 R with er");
        step(0, 0, 4'h0, "R4 idle after R");
        // R6 er during J/K
        step(1, 1, 4'h5, "R6 J with er");
        step(1, 1, 4'h5, "R6 K with er");
        step(1, 0, 4'hC, "R1 data");
        // R11 enable held through R slot
        step(0, 0, 4'h0, "R4 T");
        step(1, 0, 4'h5, "R11 R ignores en");
        step(1, 0, 4'h5, "R11 J next");
        // R7 enable drops at K
        step(0, 0, 4'h0, "R7 K completes");
        step(0, 0, 4'h0, "R7 T");
        step(0, 0, 4'h0, "R7 R");
        // R7 enable drops right after J
        step(1, 0, 4'h5, "R7 J");
        step(0, 0, 4'h0, "R7 K after drop");
        step(0, 0, 4'h0, "R7 T after drop");
        step(0, 0, 4'h0, "R7 R after drop");
        step(0, 0, 4'h0, "R2 idle");

        // constrained random frames
        for (int f = 0; f < 300; f++) begin
            run = $urandom_range(0, 12);
            for (int i = 0; i < run; i++)
                step(1, ($urandom_range(0, 9) == 0), 4'($urandom), "R1/R5 random");
            run = $urandom_range(1, 4);
            for (int i = 0; i < run; i++)
                step(0, ($urandom_range(0, 3) == 0), 4'($urandom), "R2/R4 random");
        end

        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule